// File: doc/BRIEF.md
# Bidirectional BCD Counter with Parallel Load

This block is a synchronous four-bit counter that steps up or down by one on each enabled clock edge, under the control of a direction input. A synchronous load copies a four-bit value into the count. When the load is low, an active-high enable gates stepping. A parameter picks the sequence: decade mode cycles through 0 to 9, and binary mode cycles through 0 to 15.

A terminal flag shows that the count sits at the end of its sequence for the current direction. The top value (9, or 15 in binary mode) is the end when counting up, and 0 is the end when counting down. An active-low carry output goes low while the counter is enabled and at that end, so the next decade in a chain can use it as its enable. Several stages can therefore be chained into a multi-digit counter that runs in either direction.

Top module: `bcd_updown_ctr`

## Requirements
- R1: While rst_n is low, count is 0. Reset is asynchronous and active low.
- R2: With load_en low, cnt_en high and dir_down low, count rises by one on each clock edge. In decade mode (DECADE=1) it goes from 9 to 0.
- R3: With load_en low, cnt_en high and dir_down high, count falls by one on each clock edge. In decade mode it goes from 0 to 9.
- R4: With load_en low and cnt_en low, count keeps its value across the clock edge.
- R5: With load_en high, count takes load_val on the next clock edge, whatever the values of cnt_en and dir_down. Load takes priority over counting.
- R6: at_limit is 1 exactly when dir_down is 0 and count is the top value (9 in decade mode, 15 in binary mode), or when dir_down is 1 and count is 0. At all other times it is 0.
- R7: ripple_n is 0 exactly when cnt_en is 1 and at_limit is 1. At all other times it is 1.
- R8: In decade mode, a count of 10 to 15 (which only a load can produce) steps to 0 when counting up and to 9 when counting down.
- R9: In binary mode (DECADE=0), counting up goes from 15 to 0 and counting down goes from 0 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count enable, active high |
| dir_down | input | 1 | Direction: 0 counts up, 1 counts down |
| load_en | input | 1 | Synchronous parallel load |
| load_val | input | 4 | Value to load |
| count | output | 4 | Current count |
| at_limit | output | 1 | Terminal count for the current direction |
| ripple_n | output | 1 | Active-low cascade output |

## Verification
The assertions check the following on every clock cycle:
- each load is followed by the loaded value;
- the count holds when it is neither loading nor enabled;
- a wrap occurs at the end of the sequence in each direction;
- the carry output goes low only when the counter is enabled and at its terminal count.

The assertions do not show the full sequence or the exact encoding of the terminal flag. Only the bench scenarios demonstrate these. Those scenarios cover long random mixes of direction, enable and load against a bench model for both the decade variant and the binary variant. They also cover the recovery from out-of-range loads of 10 to 15 in each direction.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;
  localparam int CW = 4;
  typedef logic [CW-1:0] cnt_t;

  // last value of the sequence for the selected variant
  function automatic cnt_t seq_top(input bit decade);
    return decade ? cnt_t'(9) : cnt_t'((1 << CW) - 1);
  endfunction

  // one step upward; values beyond the top fall back to zero
  function automatic cnt_t step_up(input cnt_t v, input bit decade);
    if (v >= seq_top(decade)) return '0;
    return v + cnt_t'(1);
  endfunction

  // one step downward; zero and out-of-range values go to the top
  function automatic cnt_t step_down(input cnt_t v, input bit decade);
    if (v == '0 || v > seq_top(decade)) return seq_top(decade);
    return v - cnt_t'(1);
  endfunction

  function automatic logic at_end(input cnt_t v, input bit down, input bit decade);
    return down ? (v == '0) : (v == seq_top(decade));
  endfunction
endpackage

// File: rtl/ctr_next.sv
module ctr_next
  import bcd_ctr_pkg::*;
#(
  parameter bit DECADE = 1'b1
) (
  input  cnt_t cur,
  input  logic dir_down,
  input  logic go,
  input  logic load_en,
  input  cnt_t load_val,
  output cnt_t nxt
);
  cnt_t stepped;

  always_comb begin
    stepped = dir_down ? step_down(cur, DECADE) : step_up(cur, DECADE);
    if (load_en)  nxt = load_val;
    else if (go)  nxt = stepped;
    else          nxt = cur;
  end
endmodule

// File: rtl/ctr_term.sv
module ctr_term
  import bcd_ctr_pkg::*;
#(
  parameter bit DECADE = 1'b1
) (
  input  cnt_t cur,
  input  logic dir_down,
  input  logic cnt_en,
  output logic limit,
  output logic carry_n
);
  always_comb begin
    limit   = at_end(cur, dir_down, DECADE);
    carry_n = ~(cnt_en & limit);
  end
endmodule

// File: rtl/bcd_updown_ctr.sv
module bcd_updown_ctr
  import bcd_ctr_pkg::*;
#(
  parameter bit DECADE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          dir_down,
  input  logic          load_en,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count,
  output logic          at_limit,
  output logic          ripple_n
);
  cnt_t count_q;
  cnt_t count_d;
  logic cnt_go;   // a counting step happens this cycle

  assign cnt_go = cnt_en & ~load_en;

  ctr_next #(.DECADE(DECADE)) u_next (
    .cur      (count_q),
    .dir_down (dir_down),
    .go       (cnt_go),
    .load_en  (load_en),
    .load_val (load_val),
    .nxt      (count_d)
  );

  ctr_term #(.DECADE(DECADE)) u_term (
    .cur      (count_q),
    .dir_down (dir_down),
    .cnt_en   (cnt_en),
    .limit    (at_limit),
    .carry_n  (ripple_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;
endmodule

// File: rtl/bcd_updown_ctr_chk.sv
module bcd_updown_ctr_chk #(
  parameter bit DECADE = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cnt_en,
  input logic       dir_down,
  input logic       load_en,
  input logic [3:0] load_val,
  input logic [3:0] count,
  input logic       at_limit,
  input logic       ripple_n,
  input logic       cnt_go
);
  localparam logic [3:0] TOPV = DECADE ? 4'd9 : 4'd15;

  a_r5_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> count == $past(load_val));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !load_en) |=> $stable(count));

  a_r2_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_go && !dir_down && count == TOPV) |=> count == 4'd0);

  a_r3_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_go && dir_down && count == 4'd0) |=> count == TOPV);

  a_r7_ripple: assert property (@(posedge clk) disable iff (!rst_n)
    !ripple_n |-> (cnt_en && at_limit));

  a_r6_limit_down: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_down && count != 4'd0) |-> !at_limit);
endmodule

bind bcd_updown_ctr bcd_updown_ctr_chk #(.DECADE(DECADE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .dir_down(dir_down),
  .load_en(load_en), .load_val(load_val), .count(count),
  .at_limit(at_limit), .ripple_n(ripple_n), .cnt_go(cnt_go)
);

// File: tb/bcd_updown_ctr_test.sv
module bcd_updown_ctr_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0, dir_down = 1'b0, load_en = 1'b0;
  logic [3:0] load_val = '0;
  logic [3:0] cnt_d, cnt_b;
  logic lim_d, lim_b, rip_d, rip_b;
  int checks = 0, errors = 0;
  int md = 0, mb = 0;   // model counts: decade, binary
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  bcd_updown_ctr #(.DECADE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .dir_down(dir_down),
    .load_en(load_en), .load_val(load_val), .count(cnt_d),
    .at_limit(lim_d), .ripple_n(rip_d));

  bcd_updown_ctr #(.DECADE(1'b0)) uut_bin (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .dir_down(dir_down),
    .load_en(load_en), .load_val(load_val), .count(cnt_b),
    .at_limit(lim_b), .ripple_n(rip_b));

  function automatic int model_next(int cur, bit en, bit dn, bit ld, int val, int modv);
    if (ld) return val;
    if (!en) return cur;
    if (cur >= modv) return dn ? modv - 1 : 0;      // R8 recovery
    return dn ? (cur + modv - 1) % modv : (cur + 1) % modv;
  endfunction

  function automatic bit model_lim(int cur, bit dn, int modv);
    return dn ? (cur == 0) : (cur == modv - 1);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit en, bit dn, bit ld, logic [3:0] val, string req);
    @(negedge clk);
    cnt_en = en; dir_down = dn; load_en = ld; load_val = val;
    #1;
    chk("R6 decade at_limit", lim_d, model_lim(md, dn, 10));
    chk("R6 binary at_limit", lim_b, model_lim(mb, dn, 16));
    chk("R7 decade ripple_n", rip_d, !(en && model_lim(md, dn, 10)));
    chk("R7 binary ripple_n", rip_b, !(en && model_lim(mb, dn, 16)));
    md = model_next(md, en, dn, ld, int'(val), 10);
    mb = model_next(mb, en, dn, ld, int'(val), 16);
    @(posedge clk); #1;
    chk({req, " decade count"}, cnt_d, md);
    chk({req, " binary count"}, cnt_b, mb);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1234;
    void'($urandom(seed));
    #35;
    chk("R1 reset decade", cnt_d, 0);
    chk("R1 reset binary", cnt_b, 0);
    @(negedge clk); rst_n = 1'b1;
    // R2 up run through wrap 9->0
    for (int i = 0; i < 12; i++) step(1, 0, 0, 4'd0, "R2 up");
    // R3 down run through 0->9 and binary 0->15
    step(1, 0, 1, 4'd0, "R5 load 0");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 4'd0, "R3 down");
    // R4 hold
    for (int i = 0; i < 3; i++) step(0, i[0], 0, 4'd0, "R4 hold");
    // R5 load with enable low
    step(0, 0, 1, 4'd7, "R5 load");
    // R8 out-of-range recovery
    step(1, 1, 1, 4'd12, "R5 load 12");
    step(1, 0, 0, 4'd0, "R8 up from 12");
    step(1, 0, 1, 4'd14, "R5 load 14");
    step(1, 1, 0, 4'd0, "R8 down from 14");
    // R9 binary wraps
    step(1, 0, 1, 4'd15, "R5 load 15");
    step(1, 0, 0, 4'd0, "R9 up wrap");
    step(1, 1, 0, 4'd0, "R9 down wrap");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[2], (r[5:3] == 3'd0), r[9:6], "R2/R3/R5 random");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule